// File: doc/BRIEF.md
# Multi-Level Interrupt Priority Controller

This block gathers up to 32 interrupt request lines, plus a small set of timer compare-match strobes that are routed onto chosen lines, into a pending register. A software-written enable mask is combined with that register. Each line is assigned to one priority level through a per-level membership mask. The block reports the highest level that holds an enabled pending line and lies strictly above the processor's current interrupt level. That result is given as a binary level number on `irq_level`, with a single request output `irq_req` beside it.

Each line is either level-type or edge-type, and this is fixed by a parameter. A level-type bit follows its input: it is set while the input is high and cleared once the input drops. An edge-type bit is set by the input and then held until software writes a 1 to the matching bit of `clear_mask`. If a new assertion arrives in the same cycle as the clear, the assertion wins. The level count (up to 7), the line count, the level masks, the line types and the timer routing are all parameters. The pending and enable registers are visible on output ports.

Top module: `irq_level_arbiter`

## Requirements
- R1: A high request on a configured line (index below NUM_IRQ) sets its bit of `pending_out` at the next clock edge, whatever the line type.
- R2: A pending bit of a level-type line (EDGE_MASK bit 0) is 0 in the cycle after its request input was low.
- R3: A pending bit of an edge-type line (EDGE_MASK bit 1) stays set until a cycle in which `clear_mask` has a 1 in that bit position and the request is low. A request in the same cycle as the clear keeps the bit set.
- R4: Bit positions at or above NUM_IRQ never become pending or enabled, and requests on them never produce an interrupt.
- R5: A high `timer_match[k]` acts as a request on line TMR_LINE[k], and that line's type then applies.
- R6: When `enable_we` is high, `enable_out` loads `enable_wdata`, restricted to the configured lines. Only bits set in both `pending_out` and `enable_out` compete, and a disabled pending bit stays pending.
- R7: `irq_level` is the largest level k (1 to NUM_LVL) whose mask LVL_MASK[k-1] overlaps the enabled pending bits and which is eligible under R8. `irq_req` is high exactly when `irq_level` is non-zero.
- R8: Only levels strictly greater than `cur_level` are eligible. If none qualifies, `irq_level` is 0 and `irq_req` is low.
- R9: `irq_level` and `irq_req` are registered from the pending register, the enable register and `cur_level`. A `cur_level` or register change therefore shows one clock later, and a request input shows two clocks after it is applied.
- R10: A synchronous active-high `rst` clears pending, enable, `irq_level` and `irq_req` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Interrupt request lines, one per bit |
| timer_match | input | NUM_TMR | Timer compare-match strobes, routed to lines by TMR_LINE |
| clear_mask | input | 32 | Write-one-to-clear for latched edge-type bits |
| enable_we | input | 1 | Loads the enable register |
| enable_wdata | input | 32 | New enable mask |
| cur_level | input | 3 | Processor's current interrupt level |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_level | output | 3 | Winning level, 0 when none |
| pending_out | output | 32 | Pending register |
| enable_out | output | 32 | Enable register |

## Verification
The bench builds the block with NUM_IRQ=10, NUM_LVL=4 and two timers routed to line 7 (level-type) and line 4 (edge-type). Edge-type lines are 1, 4, 6 and 9, and the level-4 mask also names bit 20, which lies beyond the configured lines. With only ten lines, every one of the 1024 pending patterns can be applied at each current level from 0 to 4, each with its own enable mask. A single-line sweep over all 32 positions covers set, hold and clear behaviour per line type, as well as the ignored upper positions.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int IRQ_MAX = 32;
  localparam int LVL_MAX = 7;
  localparam int TMR_MAX = 3;
  localparam int LVL_W   = 3;
  localparam int IDX_W   = 5;

  typedef logic [LVL_MAX-1:0][IRQ_MAX-1:0] lvl_masks_t;
  typedef logic [TMR_MAX-1:0][IDX_W-1:0]   tmr_map_t;

  function automatic logic [IRQ_MAX-1:0] line_valid(input int n);
    logic [IRQ_MAX-1:0] v;
    v = '0;
    for (int i = 0; i < IRQ_MAX; i++) begin
      if (i < n) v[i] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/irqa_req_merge.sv
module irqa_req_merge import irqa_pkg::*; #(
  parameter int       NUM_TMR  = 3,
  parameter tmr_map_t TMR_LINE = {5'd2, 5'd1, 5'd0}
) (
  input  logic [IRQ_MAX-1:0] irq_in,
  input  logic [NUM_TMR-1:0] timer_match,
  output logic [IRQ_MAX-1:0] req_all
);
  logic [NUM_TMR-1:0][IRQ_MAX-1:0] tmr_hit;

  // each timer strobe becomes a one-hot request on its routed line
  for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
    always_comb begin
      tmr_hit[k] = '0;
      tmr_hit[k][TMR_LINE[k]] = timer_match[k];
    end
  end

  always_comb begin
    req_all = irq_in;
    for (int k = 0; k < NUM_TMR; k++) req_all = req_all | tmr_hit[k];
  end
endmodule

// File: rtl/irqa_pending.sv
module irqa_pending import irqa_pkg::*; #(
  parameter int                 NUM_IRQ   = 32,
  parameter logic [IRQ_MAX-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IRQ_MAX-1:0] req_all,
  input  logic [IRQ_MAX-1:0] clear_mask,
  output logic [IRQ_MAX-1:0] pend_q
);
  localparam logic [IRQ_MAX-1:0] VALID = line_valid(NUM_IRQ);

  logic [IRQ_MAX-1:0] pend_d;

  for (genvar i = 0; i < IRQ_MAX; i++) begin : g_line
    if (i >= NUM_IRQ) begin : g_absent
      assign pend_d[i] = 1'b0;
    end else if (EDGE_MASK[i]) begin : g_edge
      // latched: request wins over a same-cycle clear
      assign pend_d[i] = req_all[i] | (pend_q[i] & ~clear_mask[i]);
    end else begin : g_level
      assign pend_d[i] = req_all[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d & VALID;
  end
endmodule

// File: rtl/irqa_prio.sv
module irqa_prio import irqa_pkg::*; #(
  parameter int         NUM_LVL  = 7,
  parameter lvl_masks_t LVL_MASK = '0
) (
  input  logic [IRQ_MAX-1:0] cand,
  input  logic [LVL_W-1:0]   cur_level,
  output logic [LVL_W-1:0]   win_level
);
  logic [NUM_LVL:1] hit;

  for (genvar k = 1; k <= NUM_LVL; k++) begin : g_lvl
    assign hit[k] = (|(cand & LVL_MASK[k-1])) && (LVL_W'(k) > cur_level);
  end

  // ascending scan: the last (highest) hit overrides lower ones
  always_comb begin
    win_level = '0;
    for (int k = 1; k <= NUM_LVL; k++) begin
      if (hit[k]) win_level = LVL_W'(k);
    end
  end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter import irqa_pkg::*; #(
  parameter int                 NUM_IRQ   = 32,
  parameter int                 NUM_LVL   = 7,
  parameter int                 NUM_TMR   = 3,
  parameter lvl_masks_t         LVL_MASK  = {32'h8000_0000, 32'h7000_0000, 32'h0F00_0000,
                                             32'h00F0_0000, 32'h000F_0000, 32'h0000_FF00,
                                             32'h0000_00FF},
  parameter logic [IRQ_MAX-1:0] EDGE_MASK = 32'h00FF_0000,
  parameter tmr_map_t           TMR_LINE  = {5'd30, 5'd29, 5'd28}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IRQ_MAX-1:0] irq_in,
  input  logic [NUM_TMR-1:0] timer_match,
  input  logic [IRQ_MAX-1:0] clear_mask,
  input  logic               enable_we,
  input  logic [IRQ_MAX-1:0] enable_wdata,
  input  logic [LVL_W-1:0]   cur_level,
  output logic               irq_req,
  output logic [LVL_W-1:0]   irq_level,
  output logic [IRQ_MAX-1:0] pending_out,
  output logic [IRQ_MAX-1:0] enable_out
);
  localparam logic [IRQ_MAX-1:0] VALID = line_valid(NUM_IRQ);

  logic [IRQ_MAX-1:0] req_all;
  logic [IRQ_MAX-1:0] pend_q;
  logic [IRQ_MAX-1:0] en_q;
  logic [LVL_W-1:0]   win_level;

  irqa_req_merge #(.NUM_TMR(NUM_TMR), .TMR_LINE(TMR_LINE)) u_merge (
    .irq_in(irq_in), .timer_match(timer_match), .req_all(req_all)
  );

  irqa_pending #(.NUM_IRQ(NUM_IRQ), .EDGE_MASK(EDGE_MASK)) u_pend (
    .clk(clk), .rst(rst), .req_all(req_all), .clear_mask(clear_mask), .pend_q(pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst)            en_q <= '0;
    else if (enable_we) en_q <= enable_wdata & VALID;
  end

  irqa_prio #(.NUM_LVL(NUM_LVL), .LVL_MASK(LVL_MASK)) u_prio (
    .cand(pend_q & en_q), .cur_level(cur_level), .win_level(win_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= '0;
      irq_req   <= 1'b0;
    end else begin
      irq_level <= win_level;
      irq_req   <= (win_level != '0);
    end
  end

  assign pending_out = pend_q;
  assign enable_out  = en_q;
endmodule

// File: rtl/irqa_checker.sv
module irqa_checker import irqa_pkg::*; #(
  parameter int                 NUM_IRQ   = 32,
  parameter int                 NUM_LVL   = 7,
  parameter int                 NUM_TMR   = 3,
  parameter lvl_masks_t         LVL_MASK  = '0,
  parameter logic [IRQ_MAX-1:0] EDGE_MASK = '0,
  parameter tmr_map_t           TMR_LINE  = '0
) (
  input logic               clk,
  input logic               rst,
  input logic [IRQ_MAX-1:0] irq_in,
  input logic [NUM_TMR-1:0] timer_match,
  input logic [IRQ_MAX-1:0] clear_mask,
  input logic [LVL_W-1:0]   cur_level,
  input logic               irq_req,
  input logic [LVL_W-1:0]   irq_level,
  input logic [IRQ_MAX-1:0] pending_out,
  input logic [IRQ_MAX-1:0] enable_out
);
  localparam logic [IRQ_MAX-1:0] VALID = line_valid(NUM_IRQ);

  logic [IRQ_MAX-1:0] req_chk;
  always_comb begin
    req_chk = irq_in;
    for (int k = 0; k < NUM_TMR; k++) begin
      if (timer_match[k]) req_chk[TMR_LINE[k]] = 1'b1;
    end
  end

  function automatic logic [IRQ_MAX-1:0] mask_of(input logic [LVL_W-1:0] lv);
    logic [IRQ_MAX-1:0] m;
    m = '0;
    for (int k = 1; k <= NUM_LVL; k++) begin
      if (lv == LVL_W'(k)) m = LVL_MASK[k-1];
    end
    return m;
  endfunction

  assert_set_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pending_out & $past(req_chk & VALID)) == $past(req_chk & VALID)));

  assert_level_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pending_out & ~EDGE_MASK & ~$past(req_chk)) == '0));

  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(pending_out) & EDGE_MASK & ~$past(clear_mask) & ~pending_out) == '0));

  assert_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    ((pending_out | enable_out) & ~VALID) == '0);

  assert_winner_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && irq_req) |-> ((mask_of(irq_level) & $past(pending_out & enable_out)) != '0));

  assert_above_cur_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && irq_req) |-> (irq_level > $past(cur_level)));

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (irq_level == '0 && !irq_req && pending_out == '0 && enable_out == '0));
endmodule

bind irq_level_arbiter irqa_checker #(
  .NUM_IRQ(NUM_IRQ), .NUM_LVL(NUM_LVL), .NUM_TMR(NUM_TMR),
  .LVL_MASK(LVL_MASK), .EDGE_MASK(EDGE_MASK), .TMR_LINE(TMR_LINE)
) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .timer_match(timer_match),
  .clear_mask(clear_mask), .cur_level(cur_level), .irq_req(irq_req),
  .irq_level(irq_level), .pending_out(pending_out), .enable_out(enable_out)
);

// File: tb/sim_irq_level_arbiter.sv
module sim_irq_level_arbiter;
  import irqa_pkg::*;

  localparam int NI = 10;
  localparam int NL = 4;
  localparam int NT = 2;
  localparam lvl_masks_t MASKS = {32'h0, 32'h0, 32'h0, 32'h0010_0300,
                                  32'h0000_00E0, 32'h0000_0018, 32'h0000_0007};
  localparam logic [31:0] EDGES = 32'h0000_0252;
  localparam tmr_map_t TMAP = {5'd0, 5'd4, 5'd7};
  localparam logic [31:0] VAL = 32'h0000_03FF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic [NT-1:0] timer_match = '0;
  logic [31:0] clear_mask = '0;
  logic enable_we = 1'b0;
  logic [31:0] enable_wdata = '0;
  logic [2:0] cur_level = '0;
  logic irq_req;
  logic [2:0] irq_level;
  logic [31:0] pending_out, enable_out;

  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_level_arbiter #(.NUM_IRQ(NI), .NUM_LVL(NL), .NUM_TMR(NT), .LVL_MASK(MASKS),
                      .EDGE_MASK(EDGES), .TMR_LINE(TMAP)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .timer_match(timer_match),
    .clear_mask(clear_mask), .enable_we(enable_we), .enable_wdata(enable_wdata),
    .cur_level(cur_level), .irq_req(irq_req), .irq_level(irq_level),
    .pending_out(pending_out), .enable_out(enable_out));

  function automatic logic [2:0] model_lvl(input logic [31:0] cand, input logic [2:0] cur);
    for (int k = NL; k >= 1; k--) begin
      if (k > cur && (MASKS[k-1] & cand & VAL) != 0) return 3'(k);
    end
    return 3'd0;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [2:0] lv);
    chk({req, " level"}, {29'd0, irq_level}, {29'd0, lv});
    chk({req, " req"}, {31'd0, irq_req}, {31'd0, (lv != 0)});
  endtask

  task automatic wipe();
    irq_in = '0; timer_match = '0; clear_mask = '1;
    tick();
    clear_mask = '0;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      misses++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    // R10 reset state, with requests and writes held during reset
    irq_in = '1; enable_we = 1'b1; enable_wdata = '1;
    repeat (3) tick();
    irq_in = '0; enable_we = 1'b0; enable_wdata = '0;
    chk("R10 pending", pending_out, 32'h0);
    chk("R10 enable", enable_out, 32'h0);
    chk_out("R10", 3'd0);
    rst = 1'b0;
    tick();

    // R6 enable load is masked to configured lines (R4)
    enable_we = 1'b1; enable_wdata = '1;
    tick();
    enable_we = 1'b0;
    chk("R6 R4 enable load", enable_out, VAL);

    // single-line sweep over every position: R1 R2 R3 R4 R7
    for (int i = 0; i < 32; i++) begin
      logic [31:0] bitv, setv, heldv;
      bitv  = 32'd1 << i;
      setv  = bitv & VAL;
      heldv = setv & EDGES;
      wipe();
      irq_in = bitv;
      tick();
      chk("R1 R4 set", pending_out, setv);
      irq_in = '0;
      tick();
      chk_out("R7 single", model_lvl(setv, 3'd0));
      tick();
      chk("R2 R3 R4 after release", pending_out, heldv);
      chk_out("R3 R4 after release", model_lvl(heldv, 3'd0));
    end

    // R3 clear of latched edge line 9, and assertion winning over clear
    wipe();
    irq_in = 32'h200; tick(); irq_in = '0; tick();
    chk("R3 latched", pending_out, 32'h200);
    irq_in = 32'h200; clear_mask = 32'h200; tick();
    irq_in = '0; clear_mask = '0;
    chk("R3 request beats clear", pending_out, 32'h200);
    tick();
    chk("R3 still latched", pending_out, 32'h200);
    clear_mask = 32'h200; tick(); clear_mask = '0;
    chk("R3 cleared", pending_out, 32'h0);

    // R5 timers: timer 0 -> line 7 (level), timer 1 -> line 4 (edge)
    wipe();
    timer_match = 2'b01; tick();
    chk("R5 timer0 sets line 7", pending_out, 32'h80);
    timer_match = 2'b00; tick();
    chk("R5 timer0 level line drops", pending_out, 32'h0);
    timer_match = 2'b10; tick(); timer_match = 2'b00; tick();
    chk("R5 timer1 edge line held", pending_out, 32'h10);
    chk_out("R5 timer1 level", 3'd2);

    // R6 disabled pending stays pending and gives no request
    wipe();
    enable_we = 1'b1; enable_wdata = 32'h0FF; tick(); enable_we = 1'b0;
    irq_in = 32'h300; tick(); tick();
    chk("R6 disabled still pending", pending_out, 32'h300);
    chk_out("R6 disabled", 3'd0);

    // R9 latency: input -> output two clocks, cur_level -> one clock
    enable_we = 1'b1; enable_wdata = '1; irq_in = '0; tick(); enable_we = 1'b0;
    wipe(); tick();
    irq_in = 32'h100;
    tick();
    chk_out("R9 one clock after input", 3'd0);
    tick();
    chk_out("R9 two clocks after input", 3'd4);
    cur_level = 3'd4;
    tick();
    chk_out("R9 R8 cur_level one clock", 3'd0);
    cur_level = 3'd3;
    tick();
    chk_out("R9 R8 cur_level lowered", 3'd4);
    cur_level = 3'd0;

    // exhaustive pending patterns x current level with varied enables: R6 R7 R8
    clear_mask = '1;
    for (int p = 0; p < 1024; p++) begin
      for (int c = 0; c <= 4; c++) begin
        logic [31:0] e;
        e = 32'((p * 37 + c * 91) ^ 32'h2A5) & 32'h3FF;
        if (c == 4) e = 32'h3FF;
        irq_in = 32'(p); cur_level = 3'(c);
        enable_we = 1'b1; enable_wdata = e;
        tick();
        enable_we = 1'b0;
        tick();
        chk("R6 sweep pending", pending_out, 32'(p));
        chk_out("R7 R8 sweep", model_lvl(32'(p) & e, 3'(c)));
      end
    end
    clear_mask = '0; irq_in = '0; cur_level = '0;

    // R10 reset mid-operation
    irq_in = 32'h3FF; tick(); tick();
    rst = 1'b1; tick(); rst = 1'b0; irq_in = '0;
    chk("R10 pending after reset", pending_out, 32'h0);
    chk("R10 enable after reset", enable_out, 32'h0);
    chk_out("R10 after reset", 3'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule